// File: doc/BRIEF.md
# Machine Trap Vector Register with Vectored Dispatch

This block holds the machine-mode trap vector register and works out where the core fetches from when it takes a trap. The register has two fields. One is a word-aligned handler base address, which keeps only the address bits above bit 1. The other is a two-bit dispatch mode. Software reads and writes the register as a single XLEN-bit word. A write that carries an unsupported mode encoding still updates the base, but the stored mode stays as it was.

The trap logic supplies the current cause word. Its most significant bit flags an interrupt. In vectored mode an interrupt is sent to the base plus four times the cause word, computed in XLEN-bit arithmetic so the interrupt flag shifts out. Synchronous exceptions always go to the base, and so does every trap in direct mode. A separate resume request can replace the computed address with a caller-supplied program counter.

Top module: `tvec_unit`

## Requirements
- R1: A synchronous active-high reset clears the register, so `csr_rdata` reads 0 (direct mode, base 0) and `handler_pc` is 0 for any cause while no resume request is present.
- R2: `csr_rdata` always shows `{base, mode}`, with the mode in bits [1:0]. A write with `csr_we` high takes effect at the next rising edge and always loads bits [XLEN-1:2] of `csr_wdata` into the base. With `csr_we` low the register holds its value.
- R3: A write whose bits [1:0] are 00 (direct) or 01 (vectored) stores that mode.
- R4: A write whose bits [1:0] are 10 or 11 leaves the stored mode unchanged while still updating the base. For example, writing 0x201 and then 0x203 reads back 0x201. Bit 1 of `csr_rdata` is therefore never set.
- R5: In direct mode (00), `handler_pc` equals `{base, 2'b00}` for every cause word.
- R6: In vectored mode (01), when cause bit XLEN-1 is set, `handler_pc` equals `{base, 2'b00}` plus the cause word shifted left by two, both taken modulo 2^XLEN. For example, base 0x200 with cause 0x80000010 gives 0x240.
- R7: In vectored mode, when cause bit XLEN-1 is clear, `handler_pc` equals `{base, 2'b00}`.
- R8: While `resume_en` is high, `handler_pc` equals `resume_pc`, combinationally.
- R9: While `resume_en` is low, bits [1:0] of `handler_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write enable |
| csr_wdata | input | XLEN | Value written to the register |
| csr_rdata | output | XLEN | Register contents, `{base, mode}` |
| trap_cause | input | XLEN | Current cause word; bit XLEN-1 set means interrupt |
| resume_en | input | 1 | Select `resume_pc` instead of the computed handler address |
| resume_pc | input | XLEN | Address that is output while `resume_en` is high |
| handler_pc | output | XLEN | Address the core fetches from when the trap is taken |

## Verification
The bench builds the block with XLEN = 32. With this width, the example encodings and cause words such as 0x80000010 and 0x80000011 can be checked directly. It also lets random 32-bit bases land near the top of the address space, so the sum of base and shifted cause wraps past 2^32. The cause stimulus is random and covers both values of the interrupt flag together with low and high cause numbers, which exercises every path through the address selection. Writes use all four mode encodings, and the bench keeps the base of each illegal-mode write to check that the base still updates.

// File: rtl/tvec_pkg.sv
package tvec_pkg;

  localparam int TV_MODE_W = 2;

  typedef enum logic [TV_MODE_W-1:0] {
    TV_DIRECT   = 2'b00,
    TV_VECTORED = 2'b01
  } tv_mode_e;

  // Only the two defined dispatch encodings may be stored.
  function automatic logic tv_mode_legal(input logic [TV_MODE_W-1:0] enc);
    return (enc == TV_DIRECT) || (enc == TV_VECTORED);
  endfunction

endpackage

// File: rtl/tvec_store.sv
module tvec_store
  import tvec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [XLEN-1:0]        wr_word,
  output logic [XLEN-TV_MODE_W-1:0] base_q,
  output tv_mode_e               mode_q,
  output logic                   mode_accept
);

  localparam int BASE_W = XLEN - TV_MODE_W;

  // Named event: this write carries a storable mode encoding.
  assign mode_accept = wr_en && tv_mode_legal(wr_word[TV_MODE_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mode_q <= TV_DIRECT;
    end else if (wr_en) begin
      base_q <= wr_word[XLEN-1 -: BASE_W];
      if (mode_accept) begin
        mode_q <= tv_mode_e'(wr_word[TV_MODE_W-1:0]);
      end
    end
  end

endmodule

// File: rtl/tvec_target.sv
module tvec_target
  import tvec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-TV_MODE_W-1:0] base_q,
  input  tv_mode_e                  mode_q,
  input  logic [XLEN-1:0]           cause,
  output logic [XLEN-1:0]           target,
  output logic                      vec_taken
);

  localparam int BASE_W = XLEN - TV_MODE_W;

  function automatic logic [XLEN-1:0] base_addr(input logic [BASE_W-1:0] b);
    return {b, {TV_MODE_W{1'b0}}};
  endfunction

  // Four times the cause word, truncated to XLEN; the interrupt flag drops out.
  function automatic logic [XLEN-1:0] cause_offset(input logic [XLEN-1:0] c);
    return {c[XLEN-3:0], 2'b00};
  endfunction

  logic [XLEN-1:0] offset;

  assign vec_taken = cause[XLEN-1] && (mode_q == TV_VECTORED);
  assign offset    = vec_taken ? cause_offset(cause) : '0;
  assign target    = base_addr(base_q) + offset;

endmodule

// File: rtl/tvec_unit.sv
module tvec_unit
  import tvec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] trap_cause,
  input  logic            resume_en,
  input  logic [XLEN-1:0] resume_pc,
  output logic [XLEN-1:0] handler_pc
);

  localparam int BASE_W = XLEN - TV_MODE_W;

  logic [BASE_W-1:0] base_q;
  tv_mode_e          mode_q;
  logic              mode_accept;
  logic              vec_taken;
  logic [XLEN-1:0]   target;

  tvec_store #(.XLEN(XLEN)) u_store (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (csr_we),
    .wr_word     (csr_wdata),
    .base_q      (base_q),
    .mode_q      (mode_q),
    .mode_accept (mode_accept)
  );

  tvec_target #(.XLEN(XLEN)) u_target (
    .base_q    (base_q),
    .mode_q    (mode_q),
    .cause     (trap_cause),
    .target    (target),
    .vec_taken (vec_taken)
  );

  assign csr_rdata  = {base_q, mode_q};
  assign handler_pc = resume_en ? resume_pc : target;

endmodule

// File: rtl/tvec_unit_chk.sv
module tvec_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] trap_cause,
  input logic            resume_en,
  input logic [XLEN-1:0] resume_pc,
  input logic [XLEN-1:0] handler_pc,
  input logic            mode_accept,
  input logic            vec_taken
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> csr_rdata == '0); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !csr_we |=> $stable(csr_rdata)); // R2

  AST_BASE_LOADS: assert property (@(posedge clk) disable iff (rst)
    csr_we |=> csr_rdata[XLEN-1:2] == $past(csr_wdata[XLEN-1:2])); // R2

  AST_LEGAL_MODE_STORED: assert property (@(posedge clk) disable iff (rst)
    mode_accept |=> csr_rdata[1:0] == $past(csr_wdata[1:0])); // R3

  AST_ILLEGAL_MODE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (csr_we && csr_wdata[1]) |=> csr_rdata[1:0] == $past(csr_rdata[1:0])); // R4

  AST_MODE_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[1] == 1'b0); // R4

  AST_DIRECT_BASE: assert property (@(posedge clk) disable iff (rst)
    (!resume_en && csr_rdata[1:0] == 2'b00) |-> handler_pc == {csr_rdata[XLEN-1:2], 2'b00}); // R5

  AST_VECTOR_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (!resume_en && vec_taken) |->
      handler_pc == {csr_rdata[XLEN-1:2], 2'b00} + {trap_cause[XLEN-3:0], 2'b00}); // R6

  AST_EXCEPTION_BASE: assert property (@(posedge clk) disable iff (rst)
    (!resume_en && !trap_cause[XLEN-1]) |-> handler_pc == {csr_rdata[XLEN-1:2], 2'b00}); // R7

  AST_RESUME_WINS: assert property (@(posedge clk) disable iff (rst)
    resume_en |-> handler_pc == resume_pc); // R8

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    !resume_en |-> handler_pc[1:0] == 2'b00); // R9

endmodule

bind tvec_unit tvec_unit_chk #(.XLEN(XLEN)) i_tvec_unit_chk (
  .clk         (clk),
  .rst         (rst),
  .csr_we      (csr_we),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .trap_cause  (trap_cause),
  .resume_en   (resume_en),
  .resume_pc   (resume_pc),
  .handler_pc  (handler_pc),
  .mode_accept (mode_accept),
  .vec_taken   (vec_taken)
);

// File: tb/test_tvec_unit.sv
module test_tvec_unit;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            csr_we;
  logic [XLEN-1:0] csr_wdata;
  logic [XLEN-1:0] csr_rdata;
  logic [XLEN-1:0] trap_cause;
  logic            resume_en;
  logic [XLEN-1:0] resume_pc;
  logic [XLEN-1:0] handler_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [XLEN-1:0] m_reg;

  always #5 clk = ~clk;

  tvec_unit #(.XLEN(XLEN)) i_tvec_unit (
    .clk        (clk),
    .rst        (rst),
    .csr_we     (csr_we),
    .csr_wdata  (csr_wdata),
    .csr_rdata  (csr_rdata),
    .trap_cause (trap_cause),
    .resume_en  (resume_en),
    .resume_pc  (resume_pc),
    .handler_pc (handler_pc)
  );

  // Register value after a write: the base always follows, the mode only if 00 or 01.
  function automatic logic [XLEN-1:0] after_write(input logic [XLEN-1:0] old, input logic [XLEN-1:0] wd);
    logic [XLEN-1:0] r;
    r = wd;
    if (wd[1]) r[1:0] = old[1:0];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] want_pc(input logic [XLEN-1:0] rv, input logic [XLEN-1:0] c,
                                              input logic ovr, input logic [XLEN-1:0] rpc);
    logic [XLEN-1:0] b;
    if (ovr) return rpc;
    b = rv & ~32'h3;
    if (rv[1:0] == 2'b01 && c[XLEN-1]) return b + c * 4;
    return b;
  endfunction

  function automatic string pc_req(input logic [XLEN-1:0] rv, input logic [XLEN-1:0] c, input logic ovr);
    if (ovr) return "R8";
    if (rv[1:0] == 2'b00) return "R5";
    if (c[XLEN-1]) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, compare the combinational outputs, then clock once.
  task automatic step(input logic we, input logic [XLEN-1:0] wd, input logic [XLEN-1:0] c,
                      input logic ovr, input logic [XLEN-1:0] rpc);
    @(negedge clk);
    csr_we = we; csr_wdata = wd; trap_cause = c; resume_en = ovr; resume_pc = rpc;
    #1;
    check("R2", csr_rdata, m_reg);
    check(pc_req(m_reg, c, ovr), handler_pc, want_pc(m_reg, c, ovr, rpc));
    if (!ovr) check("R9", {30'd0, handler_pc[1:0]}, '0);
    @(posedge clk);
    if (we) m_reg = after_write(m_reg, wd);
  endtask

  task automatic wr(input logic [XLEN-1:0] wd);
    step(1'b1, wd, '0, 1'b0, '0);
  endtask

  task automatic probe(input string req, input logic [XLEN-1:0] c, input logic ovr,
                       input logic [XLEN-1:0] rpc, input logic [XLEN-1:0] exp);
    @(negedge clk);
    csr_we = 1'b0; trap_cause = c; resume_en = ovr; resume_pc = rpc;
    #1;
    check(req, handler_pc, exp);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [XLEN-1:0] seed_v;
    seed_v = $urandom(32'd2718);
    rst = 1'b1; csr_we = 1'b0; csr_wdata = '0; trap_cause = '0; resume_en = 1'b0; resume_pc = '0;
    m_reg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", csr_rdata, '0);
    probe("R1", 32'h8000_0003, 1'b0, '0, '0);

    // R4: illegal mode write keeps vectored mode from the previous write
    wr(32'h0000_0201);
    wr(32'h0000_0203);
    @(negedge clk); #1;
    check("R4", csr_rdata, 32'h0000_0201);
    // R4: base still moves on an illegal mode write
    wr(32'h0000_1002);
    @(negedge clk); #1;
    check("R4", csr_rdata, 32'h0000_1001);
    // R3: legal vectored write
    wr(32'h0000_0301);
    @(negedge clk); #1;
    check("R3", csr_rdata, 32'h0000_0301);
    probe("R6", 32'h8000_0010, 1'b0, '0, 32'h0000_0340);
    probe("R6", 32'h8000_0011, 1'b0, '0, 32'h0000_0344);
    probe("R7", 32'h0000_0011, 1'b0, '0, 32'h0000_0300);
    probe("R8", 32'h8000_0010, 1'b1, 32'hDEAD_BEEC, 32'hDEAD_BEEC);
    // R6: sum wraps modulo 2^XLEN
    wr(32'hFFFF_FFF1);
    probe("R6", 32'h8000_0010, 1'b0, '0, 32'h0000_0030);
    // R3 and R5: back to direct mode, interrupts go to the base
    wr(32'h0000_0400);
    @(negedge clk); #1;
    check("R3", csr_rdata, 32'h0000_0400);
    probe("R5", 32'h8000_0011, 1'b0, '0, 32'h0000_0400);
    probe("R5", 32'h0000_0002, 1'b0, '0, 32'h0000_0400);

    for (int i = 0; i < 600; i++) begin
      logic [XLEN-1:0] wd, c;
      logic we, ovr;
      we  = ($urandom % 3) == 0;
      wd  = $urandom;
      c   = $urandom;
      if ($urandom % 2) c = {c[XLEN-1], 26'd0, c[4:0]};
      ovr = ($urandom % 6) == 0;
      step(we, wd, c, ovr, $urandom);
    end
    report();
  end

endmodule